// File: doc/BRIEF.md
# Branch and Program Counter Unit

This block works out where execution goes next after a control-transfer instruction. The fetch stage hands it one instruction at a time, together with the machine state that instruction needs. That state is the opcode, the address the opcode was fetched from, the accumulator, the 16-bit data pointer, and the bank register named by the opcode's two low bits (the register file outside selects it). It also receives the two bytes that follow the opcode in memory. The block returns the next program counter, a flag saying whether control was transferred, and, for decrement-and-branch, the decremented register value to write back.

Two kinds of branch are relative. Both use an 8-bit two's-complement displacement, counted from the address of the displacement byte itself. Decrement-and-branch keeps its displacement in the first operand byte. Compare-and-branch has its compare value in the first operand byte and its displacement in the second. Jumps can also go to an absolute address carried in the operand bytes, to the data pointer, or to the accumulator plus the data pointer. A halt opcode stops the unit until reset.

Instructions enter through a valid/ready handshake, and results leave through a second valid/ready handshake backed by one output register. A result is held unchanged until the consumer raises `res_ready`. A new instruction is taken in the same cycle the held result leaves, so a consumer that never stalls gets one result per clock. The `halted` pin is plain status.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `halted` is 0 and `ins_ready` is 1.
- R2: An instruction is accepted on a rising edge where `ins_valid` and `ins_ready` are both 1, and its result is presented with `res_valid`=1 after that edge. While `res_valid`=1 and `res_ready`=0, every result output holds its value. `ins_ready` = not halted and (no result pending or `res_ready`=1).
- R3: Opcodes 0xD0–0xD3 (decrement-and-branch) output `res_wb_en`=1 and `res_wb_val` = `ins_breg` − 1 modulo 256. When that value is nonzero, the branch is taken, `res_taken`=1 and next PC = PC+1+sext(op1). When it is zero, `res_taken`=0 and next PC = PC+2.
- R4: Opcodes 0xD4–0xD7 compare op1 with `ins_breg`. If they differ, `res_taken`=1 and next PC = PC+2+sext(op2). If they are equal, `res_taken`=0 and next PC = PC+3.
- R5: Opcode 0xDF follows the R4 rule but compares op1 with `ins_acc`.
- R6: Opcode 0xDC gives next PC = PC+1+sext(op1) with `res_taken`=1.
- R7: Opcode 0xD8 gives next PC = {op1, op2}, with op1 as the high byte, and `res_taken`=1.
- R8: Opcode 0xDD gives next PC = zero-extended `ins_acc` + `ins_dptr`. Opcode 0xDE gives next PC = `ins_dptr`. Both set `res_taken`=1.
- R9: All next-PC arithmetic wraps modulo 2^16, in both directions.
- R10: Opcode 0xFF returns next PC = PC with `res_taken`=0. From the edge that accepts it, `halted` is 1 and `ins_ready` is 0 until reset, so no later instruction produces a result.
- R11: Any opcode not listed in R3–R10 returns next PC = PC+1 with `res_taken`=0.
- R12: `res_wb_en` is 1 only for results of opcodes 0xD0–0xD3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction bundle valid |
| ins_ready | output | 1 | Unit can accept an instruction |
| ins_opcode | input | 8 | Opcode byte |
| ins_pc | input | 16 | Address of the opcode byte |
| ins_acc | input | 8 | Accumulator value |
| ins_dptr | input | 16 | Data pointer value |
| ins_breg | input | 8 | Bank register selected by opcode bits [1:0] |
| ins_op1 | input | 8 | Byte at PC+1 |
| ins_op2 | input | 8 | Byte at PC+2 |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_pc | output | 16 | Next program counter |
| res_taken | output | 1 | Control was transferred |
| res_wb_en | output | 1 | Write `res_wb_val` back to the bank register |
| res_wb_val | output | 8 | Decremented register value |
| halted | output | 1 | Halt latched |

## Verification
The hardest situation to reach is a branch where the target lands across the 16-bit boundary while the consumer is stalling. The displacement has to be negative from a low PC, or positive from a PC near 0xFFFF. Random opcodes and addresses almost never produce this. Directed cases place the PC at 0x0000 and 0xFFFE with displacements of 0x80 and 0x7F, and the random phase holds `res_ready` low for a random number of cycles after every accept, so wrapped results are also seen held under stall. The decrement case from 1 to 0 and equal compare values are forced by copying the register value into the operand bytes for a share of the random transactions, and the freeze after halt is checked by presenting instructions that must never produce a result.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  parameter int unsigned PCB_DATA_W = 8;
  parameter int unsigned PCB_ADDR_W = 2 * PCB_DATA_W;

  typedef enum logic [3:0] {
    XK_SEQ,     // not a transfer: step one byte
    XK_DECJ,    // decrement register, branch if nonzero
    XK_CMPR,    // compare immediate with bank register
    XK_CMPA,    // compare immediate with accumulator
    XK_SHORT,   // unconditional relative
    XK_LONG,    // absolute address from operands
    XK_ACCPTR,  // accumulator plus data pointer
    XK_PTR,     // data pointer
    XK_STOP     // halt
  } xfer_kind_e;

  localparam logic [7:0] OPC_SHORT  = 8'hDC;
  localparam logic [7:0] OPC_LONG   = 8'hD8;
  localparam logic [7:0] OPC_ACCPTR = 8'hDD;
  localparam logic [7:0] OPC_PTR    = 8'hDE;
  localparam logic [7:0] OPC_CMPA   = 8'hDF;
  localparam logic [7:0] OPC_STOP   = 8'hFF;

endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int unsigned DATA_W = PCB_DATA_W
) (
  input  logic [DATA_W-1:0] opcode,
  output xfer_kind_e        kind
);

  always_comb begin
    kind = XK_SEQ;
    unique casez (opcode[7:0])
      8'b1101_00??: kind = XK_DECJ;
      8'b1101_01??: kind = XK_CMPR;
      OPC_CMPA:     kind = XK_CMPA;
      OPC_SHORT:    kind = XK_SHORT;
      OPC_LONG:     kind = XK_LONG;
      OPC_ACCPTR:   kind = XK_ACCPTR;
      OPC_PTR:      kind = XK_PTR;
      OPC_STOP:     kind = XK_STOP;
      default:      kind = XK_SEQ;
    endcase
  end

endmodule

// File: rtl/pcb_cond.sv
module pcb_cond
  import pcb_pkg::*;
#(
  parameter int unsigned DATA_W = PCB_DATA_W
) (
  input  xfer_kind_e        kind,
  input  logic [DATA_W-1:0] breg,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] cmp_imm,
  output logic [DATA_W-1:0] dec_val,
  output logic              take
);

  logic reg_differs;
  logic acc_differs;

  assign dec_val     = breg - DATA_W'(1);
  assign reg_differs = (cmp_imm != breg);
  assign acc_differs = (cmp_imm != acc);

  always_comb begin
    unique case (kind)
      XK_DECJ:   take = (dec_val != '0);
      XK_CMPR:   take = reg_differs;
      XK_CMPA:   take = acc_differs;
      XK_SHORT,
      XK_LONG,
      XK_ACCPTR,
      XK_PTR:    take = 1'b1;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcb_target.sv
module pcb_target
  import pcb_pkg::*;
#(
  parameter int unsigned DATA_W = PCB_DATA_W,
  parameter int unsigned ADDR_W = PCB_ADDR_W
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  output logic [ADDR_W-1:0] seq1,
  output logic [ADDR_W-1:0] seq2,
  output logic [ADDR_W-1:0] seq3,
  output logic [ADDR_W-1:0] rel_a,   // displacement in op1, base pc+1
  output logic [ADDR_W-1:0] rel_b,   // displacement in op2, base pc+2
  output logic [ADDR_W-1:0] abs_tgt,
  output logic [ADDR_W-1:0] accptr
);

  localparam int unsigned EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] sx1;
  logic [ADDR_W-1:0] sx2;
  logic [ADDR_W-1:0] zacc;

  generate
    if (EXT_W > 0) begin : g_ext
      assign sx1  = {{EXT_W{op1[DATA_W-1]}}, op1};
      assign sx2  = {{EXT_W{op2[DATA_W-1]}}, op2};
      assign zacc = {{EXT_W{1'b0}}, acc};
    end else begin : g_noext
      assign sx1  = op1[ADDR_W-1:0];
      assign sx2  = op2[ADDR_W-1:0];
      assign zacc = acc[ADDR_W-1:0];
    end
  endgenerate

  assign seq1    = pc + ADDR_W'(1);
  assign seq2    = pc + ADDR_W'(2);
  assign seq3    = pc + ADDR_W'(3);
  assign rel_a   = seq1 + sx1;
  assign rel_b   = seq2 + sx2;
  assign abs_tgt = ADDR_W'({op1, op2});
  assign accptr  = zacc + dptr;

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int unsigned DATA_W = PCB_DATA_W,
  parameter int unsigned ADDR_W = PCB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [DATA_W-1:0] ins_opcode,
  input  logic [ADDR_W-1:0] ins_pc,
  input  logic [DATA_W-1:0] ins_acc,
  input  logic [ADDR_W-1:0] ins_dptr,
  input  logic [DATA_W-1:0] ins_breg,
  input  logic [DATA_W-1:0] ins_op1,
  input  logic [DATA_W-1:0] ins_op2,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_pc,
  output logic              res_taken,
  output logic              res_wb_en,
  output logic [DATA_W-1:0] res_wb_val,
  output logic              halted
);

  xfer_kind_e        kind;
  logic [DATA_W-1:0] dec_val;
  logic              take;
  logic [ADDR_W-1:0] seq1, seq2, seq3, rel_a, rel_b, abs_tgt, accptr;

  pcb_decode #(.DATA_W(DATA_W)) u_dec (
    .opcode (ins_opcode),
    .kind   (kind)
  );

  pcb_cond #(.DATA_W(DATA_W)) u_cond (
    .kind    (kind),
    .breg    (ins_breg),
    .acc     (ins_acc),
    .cmp_imm (ins_op1),
    .dec_val (dec_val),
    .take    (take)
  );

  pcb_target #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tgt (
    .pc      (ins_pc),
    .acc     (ins_acc),
    .dptr    (ins_dptr),
    .op1     (ins_op1),
    .op2     (ins_op2),
    .seq1    (seq1),
    .seq2    (seq2),
    .seq3    (seq3),
    .rel_a   (rel_a),
    .rel_b   (rel_b),
    .abs_tgt (abs_tgt),
    .accptr  (accptr)
  );

  // next-PC selection
  logic [ADDR_W-1:0] nxt_pc;
  always_comb begin
    unique case (kind)
      XK_DECJ:   nxt_pc = take ? rel_a : seq2;
      XK_CMPR,
      XK_CMPA:   nxt_pc = take ? rel_b : seq3;
      XK_SHORT:  nxt_pc = rel_a;
      XK_LONG:   nxt_pc = abs_tgt;
      XK_ACCPTR: nxt_pc = accptr;
      XK_PTR:    nxt_pc = ins_dptr;
      XK_STOP:   nxt_pc = ins_pc;
      default:   nxt_pc = seq1;
    endcase
  end

  // handshake and result register
  logic accept;
  logic halt_q;
  logic vld_q;

  assign ins_ready = !halt_q && (!vld_q || res_ready);
  assign accept    = ins_valid && ins_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      halt_q     <= 1'b0;
      res_pc     <= '0;
      res_taken  <= 1'b0;
      res_wb_en  <= 1'b0;
      res_wb_val <= '0;
    end else begin
      if (accept) begin
        vld_q      <= 1'b1;
        res_pc     <= nxt_pc;
        res_taken  <= take;
        res_wb_en  <= (kind == XK_DECJ);
        res_wb_val <= (kind == XK_DECJ) ? dec_val : '0;
        if (kind == XK_STOP) halt_q <= 1'b1;
      end else if (res_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign res_valid = vld_q;
  assign halted    = halt_q;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [DATA_W-1:0] ins_opcode,
  input logic [ADDR_W-1:0] ins_pc,
  input logic [DATA_W-1:0] ins_acc,
  input logic [ADDR_W-1:0] ins_dptr,
  input logic [DATA_W-1:0] ins_breg,
  input logic [DATA_W-1:0] ins_op1,
  input logic [DATA_W-1:0] ins_op2,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_pc,
  input logic              res_taken,
  input logic              res_wb_en,
  input logic [DATA_W-1:0] res_wb_val,
  input logic              halted
);

  logic acc_q;
  assign acc_q = ins_valid && ins_ready;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pc) && $stable(res_taken)
                                   && $stable(res_wb_en) && $stable(res_wb_val)));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> res_valid);

  assert_decwb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && ins_opcode[7:2] == 6'b110100)
      |=> (res_wb_en && res_wb_val == $past(ins_breg) - DATA_W'(1)));

  assert_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && ins_opcode == 8'hDE) |=> (res_pc == $past(ins_dptr) && res_taken));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ins_ready);

  assert_wben_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && ins_opcode[7:2] != 6'b110100) |=> !res_wb_en);

endmodule

bind pc_branch_unit pcb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pc_branch_unit_bench.sv
module pc_branch_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [7:0]  ins_opcode = '0;
  logic [15:0] ins_pc = '0;
  logic [7:0]  ins_acc = '0;
  logic [15:0] ins_dptr = '0;
  logic [7:0]  ins_breg = '0;
  logic [7:0]  ins_op1 = '0;
  logic [7:0]  ins_op2 = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_pc;
  logic        res_taken;
  logic        res_wb_en;
  logic [7:0]  res_wb_val;
  logic        halted;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pc_branch_unit u_pc_branch_unit (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sx(input logic [7:0] d);
    return {{8{d[7]}}, d};
  endfunction

  function automatic string req_of(input logic [7:0] op);
    if (op[7:2] == 6'b110100) return "R3";
    if (op[7:2] == 6'b110101) return "R4";
    case (op)
      8'hDF: return "R5";
      8'hDC: return "R6";
      8'hD8: return "R7";
      8'hDD, 8'hDE: return "R8";
      8'hFF: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic void model(input logic [7:0] op, input logic [15:0] pc,
                                input logic [7:0] acc, input logic [15:0] dptr,
                                input logic [7:0] breg, input logic [7:0] b1,
                                input logic [7:0] b2,
                                output logic [15:0] epc, output logic etk,
                                output logic ewe, output logic [7:0] ewv);
    ewe = 1'b0; ewv = '0; etk = 1'b0;
    if (op[7:2] == 6'b110100) begin
      ewe = 1'b1; ewv = breg - 8'd1; etk = (ewv != 0);
      epc = etk ? pc + 16'd1 + sx(b1) : pc + 16'd2;
    end else if (op[7:2] == 6'b110101 || op == 8'hDF) begin
      etk = (op == 8'hDF) ? (b1 != acc) : (b1 != breg);
      epc = etk ? pc + 16'd2 + sx(b2) : pc + 16'd3;
    end else begin
      case (op)
        8'hDC: begin etk = 1; epc = pc + 16'd1 + sx(b1); end
        8'hD8: begin etk = 1; epc = {b1, b2}; end
        8'hDD: begin etk = 1; epc = {8'h00, acc} + dptr; end
        8'hDE: begin etk = 1; epc = dptr; end
        8'hFF: epc = pc;
        default: epc = pc + 16'd1;
      endcase
    end
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [15:0] pc,
                        input logic [7:0] acc, input logic [15:0] dptr,
                        input logic [7:0] breg, input logic [7:0] b1,
                        input logic [7:0] b2, input int stall);
    logic [15:0] epc; logic etk, ewe; logic [7:0] ewv;
    string r;
    r = req_of(op);
    model(op, pc, acc, dptr, breg, b1, b2, epc, etk, ewe, ewv);
    @(negedge clk);
    ins_opcode = op; ins_pc = pc; ins_acc = acc; ins_dptr = dptr;
    ins_breg = breg; ins_op1 = b1; ins_op2 = b2;
    ins_valid = 1'b1; res_ready = 1'b0;
    chk(ins_ready == 1'b1, "R2", "ins_ready before accept", ins_ready, 1);
    @(negedge clk);
    ins_valid = 1'b0;
    chk(res_valid == 1'b1, "R2", "res_valid after accept", res_valid, 1);
    chk(res_pc == epc, r, $sformatf("next pc op=%0h", op), res_pc, epc);
    chk(res_taken == etk, r, $sformatf("taken op=%0h", op), res_taken, etk);
    chk(res_wb_en == ewe, "R12", $sformatf("wb_en op=%0h", op), res_wb_en, ewe);
    if (ewe) chk(res_wb_val == ewv, "R3", "wb value", res_wb_val, ewv);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(res_valid == 1'b1 && res_pc == epc && res_taken == etk, "R2",
          "hold under stall", res_pc, epc);
    end
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "result drained", res_valid, 0);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] op, br, b1;
    int sel;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R1", "res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 0 && halted == 0, "R1", "valid/halt after reset", {res_valid, halted}, 0);
    chk(ins_ready == 1, "R1", "ready after reset", ins_ready, 1);

    // directed corners
    run_op(8'hD1, 16'h1000, 8'h00, 16'h0, 8'h01, 8'h10, 8'h00, 1); // R3 reaches zero
    run_op(8'hD2, 16'h1000, 8'h00, 16'h0, 8'h00, 8'hFE, 8'h00, 0); // R3 wraps to FF
    run_op(8'hD0, 16'h0000, 8'h00, 16'h0, 8'h05, 8'h80, 8'h00, 2); // R9 backward wrap
    run_op(8'hD5, 16'h2000, 8'h00, 16'h0, 8'h33, 8'h33, 8'h40, 0); // R4 equal
    run_op(8'hD7, 16'hFFFE, 8'h00, 16'h0, 8'h33, 8'h34, 8'h7F, 1); // R4/R9 forward wrap
    run_op(8'hDF, 16'h3000, 8'h5A, 16'h0, 8'h00, 8'h5A, 8'h10, 0); // R5 equal
    run_op(8'hDF, 16'h3000, 8'h5A, 16'h0, 8'h00, 8'h5B, 8'hF0, 0); // R5 differ
    run_op(8'hDC, 16'hFFFF, 8'h00, 16'h0, 8'h00, 8'h01, 8'h00, 0); // R6/R9 wrap
    run_op(8'hD8, 16'h1234, 8'h00, 16'h0, 8'h00, 8'hAB, 8'hCD, 0); // R7 high byte first
    run_op(8'hDD, 16'h0000, 8'hFF, 16'hFFFF, 8'h00, 8'h00, 8'h00, 0); // R8/R9
    run_op(8'hDE, 16'h0000, 8'h12, 16'h8001, 8'h00, 8'h00, 8'h00, 0); // R8
    run_op(8'hD9, 16'hFFFF, 8'h00, 16'h0, 8'h00, 8'h00, 8'h00, 0); // R11 wrap

    // back-to-back streaming, R2: both accepted on consecutive edges
    @(negedge clk);
    ins_opcode = 8'hDE; ins_dptr = 16'h4444; ins_valid = 1'b1; res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid && res_pc == 16'h4444, "R2", "stream first", res_pc, 16'h4444);
    ins_dptr = 16'h5555;
    chk(ins_ready == 1, "R2", "ready while draining", ins_ready, 1);
    @(negedge clk);
    ins_valid = 1'b0;
    chk(res_valid && res_pc == 16'h5555, "R2", "stream second", res_pc, 16'h5555);
    @(negedge clk);
    res_ready = 1'b0;

    // random phase
    for (int n = 0; n < 400; n++) begin
      sel = $urandom_range(0, 8);
      br  = 8'($urandom);
      b1  = 8'($urandom);
      case (sel)
        0: op = 8'hD0 | 8'($urandom_range(0, 3));
        1: op = 8'hD4 | 8'($urandom_range(0, 3));
        2: op = 8'hDF;
        3: op = 8'hDC;
        4: op = 8'hD8;
        5: op = 8'hDD;
        6: op = 8'hDE;
        7: op = 8'($urandom_range(0, 8'hCF));
        default: op = 8'hD9 + 8'($urandom_range(0, 2));
      endcase
      if ($urandom_range(0, 3) == 0) begin
        if (sel == 0) br = 8'h01; else b1 = br;
      end
      run_op(op, 16'($urandom), 8'(sel == 2 && b1 == br ? b1 : $urandom),
             16'($urandom), br, b1, 8'($urandom), $urandom_range(0, 2));
    end

    // halt, R10
    run_op(8'hFF, 16'h7777, 8'h00, 16'h0, 8'h00, 8'h00, 8'h00, 1);
    chk(halted == 1, "R10", "halted after stop", halted, 1);
    chk(ins_ready == 0, "R10", "not ready after stop", ins_ready, 0);
    @(negedge clk);
    ins_opcode = 8'hDE; ins_dptr = 16'h1111; ins_valid = 1'b1; res_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(res_valid == 0, "R10", "no result while halted", res_valid, 0);
    chk(halted == 1, "R10", "halt sticky", halted, 1);
    ins_valid = 1'b0; res_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(halted == 0 && ins_ready == 1, "R1", "reset clears halt", {halted, ins_ready}, 2'b01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule